// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This unit executes one-bit logic instructions against a small bit-addressable window of internal byte memory and a carry flag. Each instruction is an opcode byte and an address byte. The address byte is accepted for every opcode, but it is used only by the opcodes that name a memory bit. The address selects one bit inside a 16-byte window. The unit reads the byte that holds the bit, changes at most that bit (or the carry flag), and writes the byte back only when a memory bit is the destination. The carry flag changes only when carry is the named destination.

A host offers an instruction with a valid/ready handshake. The unit takes the instruction on the clock edge where both signals are high. It then runs a fixed read, modify and write sequence on a byte-wide memory port and raises `done` for one cycle. An opcode the unit does not know, or a bit address outside the window, is refused. The unit raises `err` for one cycle and changes nothing.

Top module: `bitproc_core`

## Requirements
- R1: Bit address N reaches memory byte 0x20 + (N >> 3), and N[2:0] selects the bit inside that byte. For example, N = 0x10 is bit 0 of byte 0x22. The memory port never addresses a byte outside 0x20 to 0x2F.
- R2: Three opcodes write a fixed or derived value into the addressed bit and leave carry unchanged. Opcode 0xD2 sets the bit, opcode 0xC2 clears it, and opcode 0xB2 inverts it.
- R3: When a memory bit is written, the other seven bits of that byte keep the values they held before the instruction.
- R4: Opcode 0x82 sets carry to carry AND bit. Opcode 0xB0 sets carry to carry AND NOT bit. Neither writes memory.
- R5: Opcode 0x72 sets carry to carry OR bit. Opcode 0xA0 sets carry to carry OR NOT bit. Neither writes memory.
- R6: Opcode 0xA2 copies the addressed bit into carry and writes no memory. Opcode 0x92 copies carry into the addressed bit and leaves carry unchanged.
- R7: Opcode 0xC3 clears carry, opcode 0xD3 sets it, and opcode 0xB3 inverts it. These three opcodes make no memory access, and their address byte is ignored, even when it is 0x80 or above.
- R8: Carry keeps its value through every instruction that does not name carry as its destination.
- R9: Two cases are refused: an opcode that is not listed in R2 to R7, and an opcode that uses a memory bit with an address of 0x80 or above. A refused instruction makes `err` high for exactly one cycle, on the cycle after acceptance. It makes no memory write, leaves carry unchanged and gives no `done`.
- R10: An accepted instruction follows a fixed timing. It reads on the first cycle after acceptance and computes on the second. It writes, if it writes at all, on the third. `done` is high for exactly the fourth cycle. `ins_ready` is low from acceptance until `done` has ended.
- R11: Only opcodes 0xD2, 0xC2, 0xB2 and 0x92 make a memory write, each exactly one. Every opcode that uses a memory bit makes exactly one read.
- R12: After reset, `ins_ready` is 1 and `carry_o`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ins_valid | input | 1 | Host offers an instruction |
| ins_ready | output | 1 | Unit is idle and takes an instruction |
| ins_opcode | input | 8 | Opcode byte |
| ins_addr | input | 8 | Bit address byte |
| mem_rd_en | output | 1 | Read strobe; data is returned on `mem_rdata` one cycle later |
| mem_wr_en | output | 1 | Write strobe |
| mem_addr | output | 8 | Byte address for read or write |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid the cycle after `mem_rd_en` |
| carry_o | output | 1 | Carry flag |
| done | output | 1 | One-cycle pulse when an instruction completes |
| err | output | 1 | One-cycle pulse when an instruction is refused |

## Verification
The bench runs every memory-bit opcode at all 128 bit addresses, with carry both set and cleared, against a byte-level shadow of the window. Three faults are the main targets, because each corrupts state in a way that is easy to miss:
- A merge that writes the wrong lane, or whole-byte data, changes neighbouring bits. The full-window compare catches this.
- A decoder that applies the inversion to the wrong operand, or that swaps AND and OR, gives the wrong carry on half of the sweep points.
- A carry register that is loaded on every instruction leaves a wrong carry behind the bit-write ops.

Refused instructions (unknown opcodes, addresses 0x80 and 0xFF) are checked for a stray write or a stray `done`. Carry-only opcodes are given an out-of-window address to show that the address is ignored.

// File: rtl/bitproc_pkg.sv
// Package for the single-bit boolean processor.
// Holds the opcode values, the decoded operation kinds and the sequencer states.
package bitproc_pkg;

    localparam logic [7:0] OPC_SET_BIT  = 8'hD2;
    localparam logic [7:0] OPC_CLR_BIT  = 8'hC2;
    localparam logic [7:0] OPC_INV_BIT  = 8'hB2;
    localparam logic [7:0] OPC_AND_C    = 8'h82;
    localparam logic [7:0] OPC_ANDN_C   = 8'hB0;
    localparam logic [7:0] OPC_OR_C     = 8'h72;
    localparam logic [7:0] OPC_ORN_C    = 8'hA0;
    localparam logic [7:0] OPC_BIT_TO_C = 8'hA2;
    localparam logic [7:0] OPC_C_TO_BIT = 8'h92;
    localparam logic [7:0] OPC_CLR_C    = 8'hC3;
    localparam logic [7:0] OPC_SET_C    = 8'hD3;
    localparam logic [7:0] OPC_INV_C    = 8'hB3;

    typedef enum logic [3:0] {
        K_SET_BIT, K_CLR_BIT, K_INV_BIT,
        K_AND_C, K_ANDN_C, K_OR_C, K_ORN_C,
        K_BIT_TO_C, K_C_TO_BIT,
        K_CLR_C, K_SET_C, K_INV_C,
        K_NONE
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_MODIFY, ST_WRITE, ST_DONE, ST_REFUSE
    } seq_state_e;

endpackage

// File: rtl/bitproc_decode.sv
// Opcode decoder.
// Maps an opcode byte to an operation kind and reports whether the opcode is
// known, whether it uses a memory bit, and whether it writes that bit back.
// Assumes a purely combinational use; the caller registers the results.
module bitproc_decode
    import bitproc_pkg::*;
(
    input  logic [7:0] opcode,
    output op_kind_e   kind,
    output logic       known,
    output logic       uses_mem,
    output logic       writes_mem
);

    // Translate the opcode into an operation kind.
    always_comb begin
        unique case (opcode)
            OPC_SET_BIT:  kind = K_SET_BIT;
            OPC_CLR_BIT:  kind = K_CLR_BIT;
            OPC_INV_BIT:  kind = K_INV_BIT;
            OPC_AND_C:    kind = K_AND_C;
            OPC_ANDN_C:   kind = K_ANDN_C;
            OPC_OR_C:     kind = K_OR_C;
            OPC_ORN_C:    kind = K_ORN_C;
            OPC_BIT_TO_C: kind = K_BIT_TO_C;
            OPC_C_TO_BIT: kind = K_C_TO_BIT;
            OPC_CLR_C:    kind = K_CLR_C;
            OPC_SET_C:    kind = K_SET_C;
            OPC_INV_C:    kind = K_INV_C;
            default:      kind = K_NONE;
        endcase
    end

    // Derive the operand-use attributes from the kind.
    always_comb begin
        known      = (kind != K_NONE);
        uses_mem   = known && !(kind inside {K_CLR_C, K_SET_C, K_INV_C});
        writes_mem = kind inside {K_SET_BIT, K_CLR_BIT, K_INV_BIT, K_C_TO_BIT};
    end

endmodule

// File: rtl/bitproc_alu.sv
// Single-bit operation unit.
// Picks one bit out of the byte that was read, applies the operation, and
// returns the merged byte and the next carry. Only the lane at bit_pos can
// differ from rd_byte. Carry passes through unless carry is the destination.
module bitproc_alu
    import bitproc_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int POS_W = $clog2(BYTE_W)
) (
    input  op_kind_e          kind,
    input  logic [BYTE_W-1:0] rd_byte,
    input  logic [POS_W-1:0]  bit_pos,
    input  logic              carry_in,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              carry_out
);

    logic src_bit;
    logic new_bit;

    assign src_bit = rd_byte[bit_pos];

    // Compute the destination bit and the next carry value.
    always_comb begin
        new_bit   = src_bit;
        carry_out = carry_in;
        unique case (kind)
            K_SET_BIT:  new_bit   = 1'b1;
            K_CLR_BIT:  new_bit   = 1'b0;
            K_INV_BIT:  new_bit   = ~src_bit;
            K_C_TO_BIT: new_bit   = carry_in;
            K_AND_C:    carry_out = carry_in & src_bit;
            K_ANDN_C:   carry_out = carry_in & ~src_bit;
            K_OR_C:     carry_out = carry_in | src_bit;
            K_ORN_C:    carry_out = carry_in | ~src_bit;
            K_BIT_TO_C: carry_out = src_bit;
            K_CLR_C:    carry_out = 1'b0;
            K_SET_C:    carry_out = 1'b1;
            K_INV_C:    carry_out = ~carry_in;
            default:    carry_out = carry_in;
        endcase
    end

    // Merge the new bit into its lane; every other lane keeps the read value.
    for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
        assign wr_byte[g] = (bit_pos == POS_W'(g)) ? new_bit : rd_byte[g];
    end

endmodule

// File: rtl/bitproc_core.sv
// Single-bit boolean processor, top level.
// Takes one opcode/address pair per handshake, checks it, and runs a fixed
// sequence: read, modify, write, done. Refused instructions take one cycle.
// Assumes memory returns read data on the cycle after the read strobe.
module bitproc_core
    import bitproc_pkg::*;
#(
    parameter logic [7:0] REGION_BASE  = 8'h20,
    parameter int         REGION_BYTES = 16,
    localparam int        IDX_W        = $clog2(REGION_BYTES),
    localparam int        BIT_LIMIT    = REGION_BYTES * 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ins_valid,
    output logic       ins_ready,
    input  logic [7:0] ins_opcode,
    input  logic [7:0] ins_addr,
    output logic       mem_rd_en,
    output logic       mem_wr_en,
    output logic [7:0] mem_addr,
    output logic [7:0] mem_wdata,
    input  logic [7:0] mem_rdata,
    output logic       carry_o,
    output logic       done,
    output logic       err
);

    seq_state_e state_q;
    op_kind_e   dec_kind, kind_q;
    logic       dec_known, dec_uses_mem, dec_writes_mem;
    logic       uses_mem_q, writes_mem_q;
    logic [2:0] pos_q;
    logic [7:0] byte_addr_q;
    logic [7:0] wbyte_q;
    logic       carry_q;
    logic [7:0] alu_byte;
    logic       alu_carry;
    logic       addr_out_of_range;
    logic       refuse;
    logic       accept;

    bitproc_decode u_decode (
        .opcode     (ins_opcode),
        .kind       (dec_kind),
        .known      (dec_known),
        .uses_mem   (dec_uses_mem),
        .writes_mem (dec_writes_mem)
    );

    bitproc_alu #(.BYTE_W(8)) u_alu (
        .kind      (kind_q),
        .rd_byte   (mem_rdata),
        .bit_pos   (pos_q),
        .carry_in  (carry_q),
        .wr_byte   (alu_byte),
        .carry_out (alu_carry)
    );

    // Decide at the handshake whether the instruction is refused.
    always_comb begin
        accept            = ins_valid && (state_q == ST_IDLE);
        addr_out_of_range = ({1'b0, ins_addr} >= 9'(BIT_LIMIT));
        refuse            = !dec_known || (dec_uses_mem && addr_out_of_range);
    end

    // Sequencer: idle, then read/modify/write/done, or a single refuse cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (accept) state_q <= refuse ? ST_REFUSE : ST_READ;
                ST_READ:   state_q <= ST_MODIFY;
                ST_MODIFY: state_q <= ST_WRITE;
                ST_WRITE:  state_q <= ST_DONE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the decoded instruction and the byte address at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q       <= K_NONE;
            uses_mem_q   <= 1'b0;
            writes_mem_q <= 1'b0;
            pos_q        <= '0;
            byte_addr_q  <= REGION_BASE;
        end else if (accept && !refuse) begin
            kind_q       <= dec_kind;
            uses_mem_q   <= dec_uses_mem;
            writes_mem_q <= dec_writes_mem;
            pos_q        <= ins_addr[2:0];
            byte_addr_q  <= REGION_BASE + 8'(ins_addr[3 +: IDX_W]);
        end
    end

    // Hold the merged byte and update carry at the end of the modify cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbyte_q <= '0;
            carry_q <= 1'b0;
        end else if (state_q == ST_MODIFY) begin
            wbyte_q <= alu_byte;
            carry_q <= alu_carry;
        end
    end

    // Drive the outputs from the sequencer state.
    always_comb begin
        ins_ready = (state_q == ST_IDLE);
        mem_rd_en = (state_q == ST_READ) && uses_mem_q;
        mem_wr_en = (state_q == ST_WRITE) && writes_mem_q;
        mem_addr  = byte_addr_q;
        mem_wdata = wbyte_q;
        carry_o   = carry_q;
        done      = (state_q == ST_DONE);
        err       = (state_q == ST_REFUSE);
    end

endmodule

// File: rtl/bitproc_chk.sv
// Checker for bitproc_core, attached with bind.
// Watches only the ports of the core and checks the timing, refusal and
// carry-preservation rules.
module bitproc_chk #(
    parameter logic [7:0] REGION_BASE  = 8'h20,
    parameter int         REGION_BYTES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ins_valid,
    input logic       ins_ready,
    input logic       mem_rd_en,
    input logic       mem_wr_en,
    input logic [7:0] mem_addr,
    input logic       carry_o,
    input logic       done,
    input logic       err
);

    localparam logic [8:0] REGION_END = 9'(REGION_BASE) + 9'(REGION_BYTES);

    AST_RD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_addr >= REGION_BASE) && ({1'b0, mem_addr} < REGION_END)); // R1

    AST_WR_TWO_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en, 2)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_FOURTH_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ins_valid && ins_ready, 4)); // R10

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en || done) |-> !ins_ready); // R10

    AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!done && !mem_wr_en && !mem_rd_en)); // R9

    AST_REFUSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R9

    AST_CARRY_KEPT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $stable(carry_o)); // R8

    AST_CARRY_KEPT_ON_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> $stable(carry_o)); // R9

endmodule

bind bitproc_core bitproc_chk #(
    .REGION_BASE  (REGION_BASE),
    .REGION_BYTES (REGION_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .ins_ready (ins_ready),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .carry_o   (carry_o),
    .done      (done),
    .err       (err)
);

// File: tb/bitproc_core_tb.sv
// Bench for bitproc_core.
// Sweeps every memory-bit opcode over all bit addresses against a shadow model.
module bitproc_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ins_valid = 1'b0;
    logic       ins_ready;
    logic [7:0] ins_opcode = 8'h00;
    logic [7:0] ins_addr = 8'h00;
    logic       mem_rd_en, mem_wr_en;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    logic       carry_o, done, err;

    int n_chk = 0;
    int n_fail = 0;
    int wr_total = 0;
    int rd_total = 0;
    int stray_total = 0;

    logic [7:0] mem_model [16];
    logic [7:0] exp_mem [16];
    logic       exp_c = 1'b0;

    always #5 clk = ~clk;

    bitproc_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_valid  (ins_valid),
        .ins_ready  (ins_ready),
        .ins_opcode (ins_opcode),
        .ins_addr   (ins_addr),
        .mem_rd_en  (mem_rd_en),
        .mem_wr_en  (mem_wr_en),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .carry_o    (carry_o),
        .done       (done),
        .err        (err)
    );

    // Memory model: one-cycle read latency; counts strobes and out-of-window accesses.
    always @(posedge clk) begin
        if (mem_wr_en || mem_rd_en) begin
            if (mem_addr < 8'h20 || mem_addr > 8'h2F) stray_total <= stray_total + 1;
        end
        if (mem_wr_en) begin
            mem_model[mem_addr[3:0]] <= mem_wdata;
            wr_total <= wr_total + 1;
        end
        if (mem_rd_en) begin
            mem_rdata <= mem_model[mem_addr[3:0]];
            rd_total <= rd_total + 1;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Shadow model of one instruction; returns expected writes and reads.
    task automatic model_apply(input logic [7:0] opc, input logic [7:0] a,
                               output int ewr, output int erd);
        int   idx = int'(a) / 8;
        int   p = int'(a) % 8;
        logic b = exp_mem[idx][p];
        ewr = 0;
        erd = 1;
        case (opc)
            8'hD2: begin exp_mem[idx][p] = 1'b1; ewr = 1; end
            8'hC2: begin exp_mem[idx][p] = 1'b0; ewr = 1; end
            8'hB2: begin exp_mem[idx][p] = ~b; ewr = 1; end
            8'h92: begin exp_mem[idx][p] = exp_c; ewr = 1; end
            8'h82: exp_c = exp_c & b;
            8'hB0: exp_c = exp_c & ~b;
            8'h72: exp_c = exp_c | b;
            8'hA0: exp_c = exp_c | ~b;
            8'hA2: exp_c = b;
            8'hC3: begin exp_c = 1'b0; erd = 0; end
            8'hD3: begin exp_c = 1'b1; erd = 0; end
            8'hB3: begin exp_c = ~exp_c; erd = 0; end
            default: erd = 0;
        endcase
    endtask

    // Issue one instruction and check timing, carry, memory and strobe counts.
    task automatic run(input logic [7:0] opc, input logic [7:0] a,
                       input bit refused, input string rq);
        int  w0 = wr_total;
        int  r0 = rd_total;
        int  ewr = 0;
        int  erd = 0;
        int  cyc = 1;
        bit  mem_ok = 1'b1;
        if (!refused) model_apply(opc, a, ewr, erd);
        @(negedge clk);
        ins_valid = 1'b1;
        ins_opcode = opc;
        ins_addr = a;
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
        chk(!ins_ready, "R10", "ready low after accept", 32'(ins_ready), 0);
        while (!(done || err) && cyc < 8) begin
            @(negedge clk);
            cyc++;
        end
        if (refused) begin
            chk(err && cyc == 1, rq, "refuse timing", 32'(cyc), 1);
            chk(!done, rq, "no done on refuse", 32'(done), 0);
        end else begin
            chk(done && cyc == 4, rq, "done cycle", 32'(cyc), 4);
        end
        chk(carry_o == exp_c, rq, "carry", 32'(carry_o), 32'(exp_c));
        for (int i = 0; i < 16; i++) begin
            if (mem_model[i] !== exp_mem[i]) begin
                if (mem_ok) chk(1'b0, rq, $sformatf("byte %0d", i), 32'(mem_model[i]), 32'(exp_mem[i]));
                mem_ok = 1'b0;
            end
        end
        if (mem_ok) chk(1'b1, rq, "memory", 0, 0);
        chk(wr_total - w0 == ewr, "R11", "write count", 32'(wr_total - w0), 32'(ewr));
        chk(rd_total - r0 == erd, "R11", "read count", 32'(rd_total - r0), 32'(erd));
    endtask

    initial begin
        logic [7:0] mem_ops [9] = '{8'hD2, 8'hC2, 8'hB2, 8'h82, 8'hB0, 8'h72, 8'hA0, 8'hA2, 8'h92};
        int ewr_d;
        int erd_d;
        for (int i = 0; i < 16; i++) begin
            mem_model[i] = 8'hA5 ^ 8'(i * 37);
            exp_mem[i] = mem_model[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(ins_ready && !carry_o && !done && !err, "R12", "reset outputs",
            {28'd0, ins_ready, carry_o, done, err}, 32'h8);

        // R1: bit 0x10 is bit 0 of byte 0x22
        run(8'hD2, 8'h10, 1'b0, "R1");
        chk(mem_model[2][0] == 1'b1, "R1", "byte 0x22 bit 0", 32'(mem_model[2]), 32'(exp_mem[2]));

        // R7: carry-only ops ignore the address byte, even out of window
        run(8'hD3, 8'hFF, 1'b0, "R7");
        run(8'hB3, 8'h90, 1'b0, "R7");
        run(8'hB3, 8'h00, 1'b0, "R7");
        run(8'hC3, 8'h80, 1'b0, "R7");

        // R9: refusals
        run(8'h00, 8'h05, 1'b1, "R9");
        run(8'hA5, 8'h05, 1'b1, "R9");
        run(8'hD3, 8'h00, 1'b0, "R9");
        run(8'hD2, 8'h80, 1'b1, "R9");
        run(8'hB2, 8'hFF, 1'b1, "R9");
        run(8'hA2, 8'h9C, 1'b1, "R9");

        // R2 R3 R4 R5 R6 R8: every memory op at every bit address, both carry values
        for (int a = 0; a < 128; a++) begin
            for (int k = 0; k < 9; k++) begin
                if (((a + k) % 2) == 0) run(8'hD3, 8'h00, 1'b0, "R7");
                else run(8'hC3, 8'h00, 1'b0, "R7");
                case (k)
                    0, 1, 2: run(mem_ops[k], 8'(a), 1'b0, "R2_R3_R8");
                    3, 4:    run(mem_ops[k], 8'(a), 1'b0, "R4");
                    5, 6:    run(mem_ops[k], 8'(a), 1'b0, "R5");
                    default: run(mem_ops[k], 8'(a), 1'b0, "R6_R3");
                endcase
            end
        end
        model_apply(8'h00, 8'h00, ewr_d, erd_d);
        chk(stray_total == 0, "R1", "out-of-window accesses", 32'(stray_total), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule